// File: doc/BRIEF.md
# Capture/compare timer with output modes

A 16-bit timer counter is shared by three capture/compare channels. The counter counts a tick stream that it picks from several tick sources and divides by 1, 2, 4 or 8. It can be stopped, count up to the channel-0 register, run freely, or count up and down between zero and the channel-0 register.

Each channel works in one of two modes. In capture mode it copies the counter into its register when the chosen edge arrives on a synchronized input. In compare mode it raises its flag when the counter reaches its register. In both modes its output pin is driven by one of eight output modes, so that pulse-width modulation runs with no software help. A missed-capture flag records a capture that overwrote a value nobody had read.

Software reaches the block through a small register port with one cycle of read latency. An interrupt-vector register names the highest-priority pending source and clears that source's flag when it is read.

Top module: `cctimer`

## Requirements
- R1: After reset the counter, all flags, all channel registers, `cc_out`, `irq` and `rdata` are zero.
- R2: Control bits [10:9] pick which `src_tick` bit clocks the counter, and bits [8:7] divide it by 1, 2, 4 or 8 (codes 0 to 3). With divide-by-4 the counter advances once per four ticks of the chosen source. Ticks on the other sources have no effect.
- R3: Control bits [6:5] set the counting mode: 0 stop, 1 up (value 0x0020), 2 continuous, 3 up/down. In up mode the counter steps 0, 1, ... up to the channel-0 register and then returns to 0.
- R4: Control bit 0 is the timer flag. It is set when a step brings the counter to zero from a non-zero value, for example the continuous wrap from 0xFFFF or the up-mode wrap from the channel-0 value.
- R5: In up/down mode the counter rises to the channel-0 value, then falls to 0, then rises again. The timer flag is set only on reaching zero while counting down.
- R6: Reading address 2 returns 2 for channel 0, 4 for channel 1, 6 for channel 2, 8 for the timer flag, or 0 if nothing is pending. A source is pending when its flag and its enable are both 1. The lowest code wins. The read clears only the flag it reports, and flags whose enable is 0 are neither reported nor cleared.
- R7: In capture mode (channel control bit 8 = 1), the edge selected by channel control bits [15:14] (0 none, 1 rising, 2 falling, 3 both) copies the counter into the channel register and sets the channel flag (bit 0). An edge that was not selected changes nothing. An external input change is captured on the third rising clock edge after it.
- R8: Channel control bits [13:12] pick the capture input: 0 for `cap_a`, 1 for `cap_b`, 2 for a constant low and 3 for a constant high. Switching the selection from 2 to 3 by software triggers a rising-edge capture.
- R9: When a capture happens before the channel register (address 8+n) has been read since the previous capture, the missed-capture flag (channel control bit 1) is set. This flag never raises `irq`.
- R10: In compare mode a step that brings the counter to the channel register value sets the channel flag.
- R11: Channel control bits [7:5] select the output mode: 0 out follows bit 2, 1 set, 2 toggle/reset, 3 set/reset, 4 toggle, 5 reset, 6 toggle/set, 7 reset/set. The first action happens on the channel's own match and the second on the channel-0 match. The channel-0 action wins when both matches fall in the same step.
- R12: `irq` is high one cycle after any flag whose enable bit is set (channel bit 4, control bit 1) is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | timer clock |
| rst | input | 1 | synchronous active-high reset |
| src_tick | input | 4 | tick enables from the clock sources, one per source |
| cap_a | input | 3 | first asynchronous capture input, one per channel |
| cap_b | input | 3 | second asynchronous capture input, one per channel |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 4 | register address: 0 control, 1 counter, 2 vector, 4+n channel control, 8+n channel register |
| wdata | input | 16 | write data |
| rdata | output | 16 | read data, valid the cycle after `rd_en` |
| cc_out | output | 3 | channel output pins |
| irq | output | 1 | interrupt request |

## Verification
The bench targets the wrap points. These are the up-mode return from the channel-0 value, the continuous wrap past 0xFFFF and the up/down turn at zero. A counter that is off by one in its limit, or that flags the upward start from zero, reads back a wrong count or a wrong timer flag. Capture is tested with an edge that was not selected, which must be ignored, with both-edge capture and with a software-triggered capture. A second unread capture must set the missed-capture flag without raising an interrupt. Pulse-width output is checked by counting high samples per period, which exposes a set/reset mix-up. A vector read over several pending flags checks the priority order, that only one flag is cleared per read, and that a flag with its enable off is left alone.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {MODE_STOP, MODE_UP, MODE_CONT, MODE_UPDN} cnt_mode_e;
  typedef enum logic [1:0] {EDGE_NONE, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_e;
  typedef enum logic [1:0] {SEL_A, SEL_B, SEL_LOW, SEL_HIGH} in_sel_e;
  typedef enum logic [2:0] {
    OM_BIT, OM_SET, OM_TOG_RST, OM_SET_RST, OM_TOG, OM_RST, OM_TOG_SET, OM_RST_SET
  } outmode_e;

  localparam logic [3:0] ADR_CTL  = 4'd0;
  localparam logic [3:0] ADR_CNT  = 4'd1;
  localparam logic [3:0] ADR_IV   = 4'd2;
  localparam logic [3:0] ADR_CCTL = 4'd4;
  localparam logic [3:0] ADR_CCR  = 4'd8;
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale #(
  parameter int NSRC = 4,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SW-1:0]   src_sel,
  input  logic [1:0]      div_sel,
  input  logic            restart,
  output logic            tick
);
  logic [2:0] div_cnt;
  logic [2:0] lim;
  logic       src_on;

  always_comb begin
    case (div_sel)
      2'd0:    lim = 3'd0;
      2'd1:    lim = 3'd1;
      2'd2:    lim = 3'd3;
      default: lim = 3'd7;
    endcase
  end

  assign src_on = src_tick[src_sel];
  assign tick   = src_on && (div_cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) div_cnt <= '0;
    else if (src_on)    div_cnt <= (div_cnt == lim) ? 3'd0 : div_cnt + 3'd1;
  end

  assert_div_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (div_cnt == lim && src_on && !restart) |=> (div_cnt == 3'd0));
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  cnt_mode_e     mode,
  input  logic [CW-1:0] period,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          step,
  output logic          zero_evt
);
  logic dir_up, dir_nxt;

  assign step = tick && (mode != MODE_STOP);

  always_comb begin
    cnt_nxt = cnt;
    dir_nxt = dir_up;
    case (mode)
      MODE_UP:   cnt_nxt = (cnt >= period) ? '0 : cnt + 1'b1;
      MODE_CONT: cnt_nxt = cnt + 1'b1;
      MODE_UPDN: begin
        if (dir_up) begin
          if (cnt >= period) begin
            cnt_nxt = (cnt == '0) ? '0 : cnt - 1'b1;
            dir_nxt = 1'b0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            cnt_nxt = (period == '0) ? '0 : CW'(1);
            dir_nxt = 1'b1;
          end else begin
            cnt_nxt = cnt - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign zero_evt = step && (cnt != '0) && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (ld) begin
      cnt    <= ld_val;
      dir_up <= 1'b1;
    end else if (step) begin
      cnt    <= cnt_nxt;
      dir_up <= dir_nxt;
    end
  end

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_UP && cnt == period && !ld) |=> (cnt == '0));
  assert_cont_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_CONT && cnt == '1 && !ld) |=> (cnt == '0));
  assert_updn_turn_R5: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_UPDN && cnt == '0 && period != '0 && !ld) |=> (cnt == CW'(1)));
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_a,
  input  logic          cap_b,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          step,
  input  logic          eq0,
  input  logic          cctl_we,
  input  logic          ccr_we,
  input  logic          ccr_rd,
  input  logic          flag_clr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] ccr,
  output logic [CW-1:0] cctl_rd,
  output logic          out_q,
  output logic          flag,
  output logic          ie
);
  edge_e    edge_sel;
  in_sel_e  in_sel;
  outmode_e omode;
  logic     cap_mode, obit, cov, unread;
  logic [1:0] sync_a, sync_b;
  logic     lvl, prev_lvl, cap_evt, eq, out_nxt;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[11:9], wdata[3]};

  always_comb begin
    case (in_sel)
      SEL_A:    lvl = sync_a[1];
      SEL_B:    lvl = sync_b[1];
      SEL_LOW:  lvl = 1'b0;
      default:  lvl = 1'b1;
    endcase
  end

  always_comb begin
    case (edge_sel)
      EDGE_RISE: cap_evt = lvl && !prev_lvl;
      EDGE_FALL: cap_evt = !lvl && prev_lvl;
      EDGE_BOTH: cap_evt = lvl ^ prev_lvl;
      default:   cap_evt = 1'b0;
    endcase
    cap_evt = cap_evt && cap_mode;
  end

  assign eq = step && (cnt_nxt == ccr);

  always_comb begin
    out_nxt = out_q;
    case (omode)
      OM_BIT:     out_nxt = obit;
      OM_SET:     if (eq) out_nxt = 1'b1;
      OM_TOG_RST: begin if (eq) out_nxt = !out_q; if (eq0) out_nxt = 1'b0; end
      OM_SET_RST: begin if (eq) out_nxt = 1'b1;   if (eq0) out_nxt = 1'b0; end
      OM_TOG:     if (eq) out_nxt = !out_q;
      OM_RST:     if (eq) out_nxt = 1'b0;
      OM_TOG_SET: begin if (eq) out_nxt = !out_q; if (eq0) out_nxt = 1'b1; end
      default:    begin if (eq) out_nxt = 1'b0;   if (eq0) out_nxt = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_lvl <= 1'b0;
    end else begin
      sync_a <= {sync_a[0], cap_a};
      sync_b <= {sync_b[0], cap_b};
      prev_lvl <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel <= EDGE_NONE;
      in_sel   <= SEL_A;
      omode    <= OM_BIT;
      cap_mode <= 1'b0;
      ie       <= 1'b0;
      obit     <= 1'b0;
      cov      <= 1'b0;
      flag     <= 1'b0;
      unread   <= 1'b0;
      ccr      <= '0;
      out_q    <= 1'b0;
    end else begin
      if (cctl_we) begin
        edge_sel <= edge_e'(wdata[15:14]);
        in_sel   <= in_sel_e'(wdata[13:12]);
        cap_mode <= wdata[8];
        omode    <= outmode_e'(wdata[7:5]);
        ie       <= wdata[4];
        obit     <= wdata[2];
        cov      <= wdata[1];
        flag     <= wdata[0];
      end
      if (flag_clr) flag <= 1'b0;
      if (cap_evt || (eq && !cap_mode)) flag <= 1'b1;
      if (cap_evt && unread) cov <= 1'b1;
      if (ccr_rd) unread <= 1'b0;
      if (cap_evt) unread <= 1'b1;
      if (ccr_we) ccr <= wdata;
      if (cap_evt) ccr <= cnt;
      out_q <= out_nxt;
    end
  end

  assign cctl_rd = CW'({edge_sel, in_sel, 3'b000, cap_mode, omode, ie, 1'b0, obit, cov, flag});

  assert_cap_flag_R7: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (flag && ccr == $past(cnt)));
  assert_missed_cap_R9: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && unread) |=> cov);
  assert_cmp_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (eq && !cap_mode) |=> flag);
  assert_om_set_R11: assert property (@(posedge clk) disable iff (rst)
    (omode == OM_SET && eq) |=> out_q);
  assert_om_rst_R11: assert property (@(posedge clk) disable iff (rst)
    (omode == OM_RST && eq) |=> !out_q);
endmodule

// File: rtl/cctimer.sv
module cctimer
  import cct_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NCH  = 3,
  parameter int NSRC = 4,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_tick,
  input  logic [NCH-1:0]  cap_a,
  input  logic [NCH-1:0]  cap_b,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [3:0]      addr,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   rdata,
  output logic [NCH-1:0]  cc_out,
  output logic            irq
);
  logic [SW-1:0] src_sel;
  logic [1:0]    div_sel;
  cnt_mode_e     mode;
  logic          tie, tflag;
  logic          ctl_we, cnt_we, iv_rd;
  logic          tick, step, zero_evt, eq0;
  logic [CW-1:0] cnt, cnt_nxt, iv_code;
  logic [CW-1:0] ccr_v  [NCH];
  logic [CW-1:0] cctl_v [NCH];
  logic [NCH-1:0] flag_v, ie_v, pend, hit_ch, clr_ch, cctl_we, ccr_we, ccr_rd;
  logic          hit_t;

  assign ctl_we = wr_en && addr == ADR_CTL;
  assign cnt_we = wr_en && addr == ADR_CNT;
  assign iv_rd  = rd_en && addr == ADR_IV;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= '0;
      div_sel <= '0;
      mode    <= MODE_STOP;
      tie     <= 1'b0;
      tflag   <= 1'b0;
    end else begin
      if (ctl_we) begin
        src_sel <= wdata[9 +: SW];
        div_sel <= wdata[8:7];
        mode    <= cnt_mode_e'(wdata[6:5]);
        tie     <= wdata[1];
        tflag   <= wdata[0];
      end
      if (hit_t && iv_rd) tflag <= 1'b0;
      if (zero_evt) tflag <= 1'b1;
    end
  end

  cct_prescale #(.NSRC(NSRC)) u_pre (
    .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
    .div_sel(div_sel), .restart(ctl_we), .tick(tick)
  );

  cct_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .period(ccr_v[0]),
    .ld(cnt_we), .ld_val(wdata), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .step(step), .zero_evt(zero_evt)
  );

  assign eq0 = step && (cnt_nxt == ccr_v[0]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cctl_we[g] = wr_en && addr == 4'(ADR_CCTL + g);
    assign ccr_we[g]  = wr_en && addr == 4'(ADR_CCR + g);
    assign ccr_rd[g]  = rd_en && addr == 4'(ADR_CCR + g);
    assign clr_ch[g]  = iv_rd && hit_ch[g];
    assign pend[g]    = flag_v[g] && ie_v[g];
    cct_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .cap_a(cap_a[g]), .cap_b(cap_b[g]),
      .cnt(cnt), .cnt_nxt(cnt_nxt), .step(step), .eq0(eq0),
      .cctl_we(cctl_we[g]), .ccr_we(ccr_we[g]), .ccr_rd(ccr_rd[g]),
      .flag_clr(clr_ch[g]), .wdata(wdata), .ccr(ccr_v[g]),
      .cctl_rd(cctl_v[g]), .out_q(cc_out[g]), .flag(flag_v[g]), .ie(ie_v[g])
    );
  end

  always_comb begin
    iv_code = '0;
    hit_ch  = '0;
    hit_t   = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        iv_code = CW'(2 * (i + 1));
        hit_ch  = '0;
        hit_ch[i] = 1'b1;
      end
    end
    if (pend == '0 && tflag && tie) begin
      iv_code = CW'(2 * (NCH + 1));
      hit_t   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= (|pend) || (tflag && tie);
      if (rd_en) begin
        rdata <= '0;
        if (addr == ADR_CTL)
          rdata <= CW'({src_sel, div_sel, mode, 3'b000, tie, tflag});
        if (addr == ADR_CNT) rdata <= cnt;
        if (addr == ADR_IV)  rdata <= iv_code;
        for (int i = 0; i < NCH; i++) begin
          if (addr == 4'(ADR_CCTL + i)) rdata <= cctl_v[i];
          if (addr == 4'(ADR_CCR + i))  rdata <= ccr_v[i];
        end
      end
    end
  end

  assert_tflag_set_R4: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> tflag);
  assert_iv_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    (iv_rd && ((|pend) || (tflag && tie))) |=> (rdata != '0));
  assert_iv_clr_timer_R6: assert property (@(posedge clk) disable iff (rst)
    (iv_rd && hit_t && !zero_evt) |=> !tflag);
  assert_one_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_ch, hit_t && iv_rd}));
endmodule

// File: tb/cctimer_tb_top.sv
module cctimer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = '0;
  logic [2:0]  cap_a = '0, cap_b = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  cc_out;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cctimer dut_i (
    .clk(clk), .rst(rst), .src_tick(src_tick), .cap_a(cap_a), .cap_b(cap_b),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cc_out(cc_out), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(logic [3:0] pat, int n);
    src_tick = pat;
    repeat (n) @(negedge clk);
    src_tick = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 cc_out", 16'(cc_out), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rd(4'd1, d); chk("R1 counter", d, 16'h0);
    rd(4'd9, d); chk("R1 ccr1", d, 16'h0);
  endtask

  task automatic t_up();
    logic [15:0] d;
    wr(4'd1, 16'h0); wr(4'd8, 16'd4); wr(4'd0, 16'h0020);
    ticks(4'b0001, 7);
    rd(4'd1, d); chk("R3 up count", d, 16'd2);
    rd(4'd0, d); chk("R4 up wrap flag", 16'(d[0]), 16'h1);
  endtask

  task automatic t_cont();
    logic [15:0] d;
    wr(4'd0, 16'h0040); wr(4'd1, 16'hFFFD);
    ticks(4'b0001, 4);
    rd(4'd1, d); chk("R4 cont count", d, 16'd1);
    rd(4'd0, d); chk("R4 cont flag", 16'(d[0]), 16'h1);
  endtask

  task automatic t_updn();
    logic [15:0] d;
    wr(4'd8, 16'd3); wr(4'd0, 16'h0060); wr(4'd1, 16'h0);
    ticks(4'b0001, 5);
    rd(4'd1, d); chk("R5 updn count", d, 16'd1);
    rd(4'd0, d); chk("R5 no flag going up", 16'(d[0]), 16'h0);
    ticks(4'b0001, 2);
    rd(4'd1, d); chk("R5 turn at zero", d, 16'd1);
    rd(4'd0, d); chk("R5 flag at zero", 16'(d[0]), 16'h1);
  endtask

  task automatic t_presc();
    logic [15:0] d;
    wr(4'd0, 16'h0540); wr(4'd1, 16'h0);
    ticks(4'b1011, 12);
    rd(4'd1, d); chk("R2 other sources ignored", d, 16'd0);
    wr(4'd0, 16'h0540);
    ticks(4'b0100, 12);
    rd(4'd1, d); chk("R2 divide by 4", d, 16'd3);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    wr(4'd0, 16'h0040);
    wr(4'd5, 16'h4110);
    wr(4'd1, 16'h1234);
    cap_a[1] = 1'b1; repeat (5) @(negedge clk);
    rd(4'd9, d); chk("R7 rising capture", d, 16'h1234);
    rd(4'd5, d); chk("R7 capture flag", 16'(d[0]), 16'h1);
    wr(4'd1, 16'h2222);
    cap_a[1] = 1'b0; repeat (5) @(negedge clk);
    rd(4'd9, d); chk("R7 falling ignored", d, 16'h1234);
    wr(4'd5, 16'hC110);
    wr(4'd1, 16'h0100);
    cap_a[1] = 1'b1; repeat (5) @(negedge clk);
    wr(4'd1, 16'h0200);
    cap_a[1] = 1'b0; repeat (5) @(negedge clk);
    rd(4'd5, d); chk("R9 missed capture", 16'(d[1]), 16'h1);
    rd(4'd9, d); chk("R7 both edges", d, 16'h0200);
    wr(4'd5, 16'hC112); repeat (3) @(negedge clk);
    chk("R9 no irq from missed", 16'(irq), 16'h0);
    wr(4'd5, 16'h0000);
  endtask

  task automatic t_swcap();
    logic [15:0] d;
    wr(4'd1, 16'h0ABC);
    wr(4'd6, 16'h6100); repeat (3) @(negedge clk);
    wr(4'd6, 16'h7100); repeat (4) @(negedge clk);
    rd(4'd10, d); chk("R8 software capture", d, 16'h0ABC);
  endtask

  task automatic t_pwm();
    logic [15:0] d;
    int h1 = 0, h2 = 0;
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0);
    wr(4'd4, 16'h0000); wr(4'd8, 16'd9);
    wr(4'd9, 16'd3); wr(4'd10, 16'd5);
    wr(4'd5, 16'h00E0); wr(4'd6, 16'h0080);
    wr(4'd0, 16'h0020);
    src_tick = 4'b0001;
    repeat (25) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cc_out[1]) h1++;
      if (cc_out[2]) h2++;
    end
    src_tick = '0;
    chk("R11 reset/set duty", 16'(h1), 16'd8);
    chk("R11 toggle duty", 16'(h2), 16'd10);
    rd(4'd5, d); chk("R10 compare flag", 16'(d[0]), 16'h1);
    wr(4'd6, 16'h0004); repeat (2) @(negedge clk);
    chk("R11 output bit high", 16'(cc_out[2]), 16'h1);
    wr(4'd6, 16'h0000); repeat (2) @(negedge clk);
    chk("R11 output bit low", 16'(cc_out[2]), 16'h0);
  endtask

  task automatic t_iv();
    logic [15:0] d;
    wr(4'd0, 16'h0003);
    wr(4'd4, 16'h0011); wr(4'd5, 16'h0001); wr(4'd6, 16'h0011);
    repeat (2) @(negedge clk);
    chk("R12 irq pending", 16'(irq), 16'h1);
    rd(4'd2, d); chk("R6 first ch0", d, 16'd2);
    rd(4'd2, d); chk("R6 then ch2", d, 16'd6);
    rd(4'd2, d); chk("R6 then timer", d, 16'd8);
    rd(4'd2, d); chk("R6 none", d, 16'd0);
    repeat (2) @(negedge clk);
    chk("R12 irq cleared", 16'(irq), 16'h0);
    rd(4'd5, d); chk("R6 masked flag kept", 16'(d[0]), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_up();
    t_cont();
    t_updn();
    t_presc();
    t_capture();
    t_swcap();
    t_pwm();
    t_iv();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule